// File: doc/BRIEF.md
# Transfer Byte Counter and Address Tracker

This block follows a data transfer one confirmed byte at a time. It holds a remaining-byte count that runs down and a transfer address that runs up by the same amount. Software sets both through a byte-wide register port before the transfer starts. The data path then reports each finished transfer with a completion strobe. A separate qualifier marks a strobe that finished two bytes at once, as on a wide bus.

Every strobe updates the count and the address together. The address therefore always points just past the last byte that actually completed, whatever the data path has already requested. Two sticky status flags record the outcome. One is set when the count reaches or passes zero. The other is set when the count underflows and rolls over. Software clears a flag by writing a one to it. Each flag has its own enable, and the interrupt output is high while any enabled flag is set.

Top module: `xfer_progress`

## Requirements
- R1: After reset the count reads 0, the address reads 0, both status flags and both enables read 0, and `irq` is low.
- R2: The count is written and read in bytes at register addresses 0x0 (bits 7:0), 0x1 (bits 15:8) and 0x2 (bits 23:16). Addresses with no register (0xA to 0xF) read as 0.
- R3: The address is written and read in bytes at 0x4 (bits 7:0), 0x5, 0x6 and 0x7 (bits 31:24).
- R4: A strobe with `comp_wide`=0 lowers the count by 1, and one with `comp_wide`=1 lowers it by 2. The count wraps modulo 2^24. The address rises by the same amount and wraps modulo 2^32. Neither register changes in any cycle without a strobe or a write to it.
- R5: A strobe sets the done flag (status bit 0 at 0x8) when the count before the strobe is less than or equal to the step. This covers both reaching zero and passing it.
- R6: A strobe sets the wrap flag (status bit 1 at 0x8) when the count before the strobe is less than the step, so that the count rolls over.
- R7: Loading the count, even with zero, and clearing it never set either flag.
- R8: Writing 0x3 with bit 0 = 1 sets the count to 0 and leaves the address unchanged. With bit 0 = 0 the write has no effect.
- R9: Writing 0x8 clears each flag whose data bit is 1 and leaves the others as they are. Flags otherwise hold until cleared.
- R10: If a strobe sets a flag in the same cycle as a write that clears it, the flag ends up set.
- R11: Register 0x9 holds the enables (bit 0 for done, bit 1 for wrap). `irq` is high exactly while some flag is set and its enable is 1.
- R12: If a register write and a strobe fall in the same cycle, the written register takes the written value. The flags and the other register still follow the strobe, using the count as it stood before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| comp_stb | input | 1 | One transfer completed this cycle |
| comp_wide | input | 1 | The completion covered two bytes |
| irq | output | 1 | Interrupt, any enabled flag set |

## Verification
A wrong count shows up at the count read addresses one cycle after the offending strobe. It also moves the done or wrap flag, which raises `irq` in that same cycle. An address that drifts out of step with the count shows at 0x4 to 0x7 right after the strobe. The sweeps therefore compare count, address and both flags after every single strobe, starting from counts 0 through 5 with both step sizes. A flag lost through a bad clear priority appears at once at 0x8 and on `irq`.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
  localparam int RAW = 4;
  localparam logic [RAW-1:0] RA_CNT0 = 4'h0;
  localparam logic [RAW-1:0] RA_CTRL = 4'h3;
  localparam logic [RAW-1:0] RA_ADR0 = 4'h4;
  localparam logic [RAW-1:0] RA_STAT = 4'h8;
  localparam logic [RAW-1:0] RA_IEN  = 4'h9;
  localparam int NFLAG    = 2;
  localparam int FL_DONE  = 0;
  localparam int FL_WRAP  = 1;
  localparam int CTL_CLR  = 0;
endpackage

// File: rtl/xfp_regif.sv
module xfp_regif
  import xfp_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int ADR_BYTES = 4
) (
  input  logic                     wr_en,
  input  logic [RAW-1:0]           wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [RAW-1:0]           rd_addr,
  input  logic [8*CNT_BYTES-1:0]   cnt_q,
  input  logic [8*ADR_BYTES-1:0]   adr_q,
  input  logic [NFLAG-1:0]         sts_q,
  input  logic [NFLAG-1:0]         ien_q,
  output logic [CNT_BYTES-1:0]     cnt_be,
  output logic [ADR_BYTES-1:0]     adr_be,
  output logic                     cnt_clr,
  output logic [NFLAG-1:0]         sts_w1c,
  output logic                     ien_we,
  output logic [7:0]               rd_data
);
  for (genvar i = 0; i < CNT_BYTES; i++) begin : g_cbe
    assign cnt_be[i] = wr_en && (wr_addr == RAW'(RA_CNT0 + i));
  end
  for (genvar j = 0; j < ADR_BYTES; j++) begin : g_abe
    assign adr_be[j] = wr_en && (wr_addr == RAW'(RA_ADR0 + j));
  end

  assign cnt_clr = wr_en && (wr_addr == RA_CTRL) && wr_data[CTL_CLR];
  assign sts_w1c = (wr_en && (wr_addr == RA_STAT)) ? wr_data[NFLAG-1:0] : '0;
  assign ien_we  = wr_en && (wr_addr == RA_IEN);

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (rd_addr == RAW'(RA_CNT0 + i)) rd_data = cnt_q[8*i +: 8];
    end
    for (int j = 0; j < ADR_BYTES; j++) begin
      if (rd_addr == RAW'(RA_ADR0 + j)) rd_data = adr_q[8*j +: 8];
    end
    if (rd_addr == RA_STAT) rd_data = {{(8-NFLAG){1'b0}}, sts_q};
    if (rd_addr == RA_IEN)  rd_data = {{(8-NFLAG){1'b0}}, ien_q};
  end
endmodule

// File: rtl/xfp_counter.sv
module xfp_counter #(
  parameter int NBYTES = 3,
  localparam int W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] be,
  input  logic [7:0]        wdata,
  input  logic              clr,
  input  logic              stb,
  input  logic              wide,
  output logic [W-1:0]      cnt_q,
  output logic              done_evt,
  output logic              wrap_evt
);
  logic [W-1:0] step;
  logic [W-1:0] cnt_d;
  logic         sw_touch;
  logic         cnt_en;

  assign step     = {{(W-2){1'b0}}, wide, ~wide};
  assign sw_touch = (|be) || clr;
  assign cnt_en   = sw_touch || stb;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (sw_touch) begin
      for (int b = 0; b < W; b++) begin
        if (be[b/8]) cnt_d[b] = wdata[b%8];
      end
    end else if (stb) begin
      cnt_d = cnt_q - step;
    end
  end

  assign done_evt = stb && (cnt_q <= step);
  assign wrap_evt = stb && (cnt_q <  step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/xfp_addr.sv
module xfp_addr #(
  parameter int NBYTES = 4,
  localparam int W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] be,
  input  logic [7:0]        wdata,
  input  logic              stb,
  input  logic              wide,
  output logic [W-1:0]      adr_q
);
  logic [W-1:0] step;
  logic [W-1:0] adr_d;
  logic         adr_en;

  assign step   = {{(W-2){1'b0}}, wide, ~wide};
  assign adr_en = (|be) || stb;

  always_comb begin
    adr_d = adr_q;
    if (|be) begin
      for (int b = 0; b < W; b++) begin
        if (be[b/8]) adr_d[b] = wdata[b%8];
      end
    end else if (stb) begin
      adr_d = adr_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      adr_q <= '0;
    else if (adr_en) adr_q <= adr_d;
  end
endmodule

// File: rtl/xfp_status.sv
module xfp_status
  import xfp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_evt,
  input  logic [NFLAG-1:0] w1c,
  input  logic             ien_we,
  input  logic [NFLAG-1:0] ien_wdata,
  output logic [NFLAG-1:0] sts_q,
  output logic [NFLAG-1:0] ien_q,
  output logic             irq
);
  logic [NFLAG-1:0] sts_d;
  logic             sts_en;

  always_comb begin
    sts_d  = (sts_q & ~w1c) | set_evt;
    sts_en = (|w1c) || (|set_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_wdata;
  end

  assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/xfer_progress.sv
module xfer_progress
  import xfp_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int ADR_BYTES = 4,
  localparam int CNT_W = 8 * CNT_BYTES,
  localparam int ADR_W = 8 * ADR_BYTES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [7:0]     rd_data,
  input  logic           comp_stb,
  input  logic           comp_wide,
  output logic           irq
);
  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  logic [CNT_BYTES-1:0] cnt_be;
  logic [ADR_BYTES-1:0] adr_be;
  logic                 cnt_clr;
  logic [NFLAG-1:0]     sts_w1c;
  logic                 ien_we;
  logic [CNT_W-1:0]     cnt_q;
  logic [ADR_W-1:0]     adr_q;
  logic [NFLAG-1:0]     sts_q;
  logic [NFLAG-1:0]     ien_q;
  logic                 done_evt;
  logic                 wrap_evt;
  logic [NFLAG-1:0]     set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  xfp_regif #(.CNT_BYTES(CNT_BYTES), .ADR_BYTES(ADR_BYTES)) u_regif (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .cnt_q(cnt_q), .adr_q(adr_q), .sts_q(sts_q), .ien_q(ien_q),
    .cnt_be(cnt_be), .adr_be(adr_be), .cnt_clr(cnt_clr), .sts_w1c(sts_w1c),
    .ien_we(ien_we), .rd_data(rd_data)
  );

  xfp_counter #(.NBYTES(CNT_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .be(cnt_be), .wdata(wr_data), .clr(cnt_clr),
    .stb(comp_stb), .wide(comp_wide), .cnt_q(cnt_q),
    .done_evt(done_evt), .wrap_evt(wrap_evt)
  );

  xfp_addr #(.NBYTES(ADR_BYTES)) u_adr (
    .clk(clk), .rst_n(rst_int_n), .be(adr_be), .wdata(wr_data),
    .stb(comp_stb), .wide(comp_wide), .adr_q(adr_q)
  );

  always_comb begin
    set_evt          = '0;
    set_evt[FL_DONE] = done_evt;
    set_evt[FL_WRAP] = wrap_evt;
  end

  xfp_status u_sts (
    .clk(clk), .rst_n(rst_int_n), .set_evt(set_evt), .w1c(sts_w1c),
    .ien_we(ien_we), .ien_wdata(wr_data[NFLAG-1:0]),
    .sts_q(sts_q), .ien_q(ien_q), .irq(irq)
  );
endmodule

// File: rtl/xfp_checker.sv
module xfp_checker
  import xfp_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int ADR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [RAW-1:0]   wr_addr,
  input logic [7:0]       wr_data,
  input logic             comp_stb,
  input logic             comp_wide,
  input logic [CNT_W-1:0] cnt_q,
  input logic [ADR_W-1:0] adr_q,
  input logic [NFLAG-1:0] sts_q,
  input logic [NFLAG-1:0] ien_q,
  input logic             irq
);
  logic cnt_sw, adr_sw, sts_wr;
  logic [CNT_W-1:0] cstep;
  logic [ADR_W-1:0] astep;

  assign cnt_sw = wr_en && ((wr_addr < RA_CTRL) || (wr_addr == RA_CTRL && wr_data[CTL_CLR]));
  assign adr_sw = wr_en && (wr_addr >= RA_ADR0) && (wr_addr < RA_STAT);
  assign sts_wr = wr_en && (wr_addr == RA_STAT);
  assign cstep  = comp_wide ? CNT_W'(2) : CNT_W'(1);
  assign astep  = comp_wide ? ADR_W'(2) : ADR_W'(1);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_stb && !cnt_sw) |=> (cnt_q == $past(cnt_q) - $past(cstep))) else $error("cnt step"); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!comp_stb && !cnt_sw) |=> $stable(cnt_q)) else $error("cnt hold"); // R4
  AST_ADR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_stb && !adr_sw) |=> (adr_q == $past(adr_q) + $past(astep))) else $error("adr step"); // R4
  AST_LOAD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_sw && !comp_stb && !sts_q[FL_DONE]) |=> !sts_q[FL_DONE]) else $error("load set done"); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[FL_DONE] && !sts_wr) |=> sts_q[FL_DONE]) else $error("done dropped"); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_stb && cnt_q == CNT_W'(1) && sts_wr) |=> sts_q[FL_DONE]) else $error("set lost"); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq) else $error("irq unmasked"); // R11
endmodule

bind xfer_progress xfp_checker #(.CNT_W(CNT_W), .ADR_W(ADR_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .comp_stb(comp_stb), .comp_wide(comp_wide),
  .cnt_q(cnt_q), .adr_q(adr_q), .sts_q(sts_q), .ien_q(ien_q), .irq(irq)
);

// File: tb/xfer_progress_bench.sv
`timescale 1ns/1ps
module xfer_progress_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       comp_stb = 1'b0;
  logic       comp_wide = 1'b0;
  logic       irq;
  int         n_chk = 0;
  int         n_err = 0;

  always #2.5 clk = ~clk;

  xfer_progress u_xfer_progress (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .comp_stb(comp_stb),
    .comp_wide(comp_wide), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock: optional register write and optional strobe in the same cycle
  task automatic cyc(input bit we, input logic [3:0] a, input logic [7:0] d,
                     input bit stb, input bit wide);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; comp_stb = stb; comp_wide = wide;
    @(negedge clk);
    wr_en = 1'b0; comp_stb = 1'b0; comp_wide = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic rd_cnt(output logic [31:0] v);
    logic [7:0] b0, b1, b2;
    rd(4'h0, b0); rd(4'h1, b1); rd(4'h2, b2);
    v = {8'h00, b2, b1, b0};
  endtask

  task automatic rd_adr(output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3;
    rd(4'h4, b0); rd(4'h5, b1); rd(4'h6, b2); rd(4'h7, b3);
    v = {b3, b2, b1, b0};
  endtask

  task automatic ld_cnt(input logic [23:0] v);
    wr(4'h0, v[7:0]); wr(4'h1, v[15:8]); wr(4'h2, v[23:16]);
  endtask

  task automatic ld_adr(input logic [31:0] v);
    wr(4'h4, v[7:0]); wr(4'h5, v[15:8]); wr(4'h6, v[23:16]); wr(4'h7, v[31:24]);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_cnt(v); check("R1 count", v, 0);
    rd_adr(v); check("R1 addr", v, 0);
    rd(4'h8, b); check("R1 status", b, 0);
    rd(4'h9, b); check("R1 enable", b, 0);
    check("R1 irq", irq, 0);

    // R2/R3/R7 loads
    ld_cnt(24'h000000);
    rd(4'h8, b); check("R7 load zero no flag", b, 0);
    ld_cnt(24'h123456);
    rd_cnt(v); check("R2 count readback", v, 32'h123456);
    ld_adr(32'h89ABCDEF);
    rd_adr(v); check("R3 addr readback", v, 32'h89ABCDEF);
    for (int a = 10; a < 16; a++) begin
      rd(4'(a), b); check("R2 unmapped reads zero", b, 0);
    end
    rd(4'h8, b); check("R7 load no flag", b, 0);
    repeat (3) @(negedge clk);
    rd_cnt(v); check("R4 idle count holds", v, 32'h123456);
    rd_adr(v); check("R4 idle addr holds", v, 32'h89ABCDEF);

    // R4/R5/R6 sweep over small starting counts and both step sizes
    for (int s = 0; s < 6; s++) begin
      for (int w = 0; w < 2; w++) begin
        logic [23:0] mc;
        logic [31:0] ma;
        bit md, mw;
        wr(4'h8, 8'h03);
        mc = 24'(s); ma = 32'hFFFF_FFFB; md = 0; mw = 0;
        ld_cnt(mc); ld_adr(ma);
        for (int k = 0; k < 4; k++) begin
          int st;
          st = w + 1;
          if (int'(mc) <= st) md = 1;
          if (int'(mc) <  st) mw = 1;
          mc = mc - 24'(st);
          ma = ma + 32'(st);
          cyc(1'b0, 4'h0, 8'h00, 1'b1, w[0]);
          rd_cnt(v); check("R4 count step", v, {8'h00, mc});
          rd_adr(v); check("R4 addr step", v, ma);
          rd(4'h8, b);
          check("R5 done flag", b[0], md);
          check("R6 wrap flag", b[1], mw);
        end
      end
    end

    // R8 clear control
    wr(4'h8, 8'h03);
    ld_cnt(24'h000007); ld_adr(32'h0000_1000);
    wr(4'h3, 8'h00);
    rd_cnt(v); check("R8 bit0 zero no effect", v, 7);
    wr(4'h3, 8'h01);
    rd_cnt(v); check("R8 clear count", v, 0);
    rd_adr(v); check("R8 addr untouched", v, 32'h1000);
    rd(4'h8, b); check("R7 clear no flag", b, 0);

    // R9 write-one-to-clear
    cyc(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);   // 0 -> wraps, both flags
    rd(4'h8, b); check("R9 both set", b, 3);
    wr(4'h8, 8'h00);
    rd(4'h8, b); check("R9 zero write keeps", b, 3);
    wr(4'h8, 8'h02);
    rd(4'h8, b); check("R9 clear wrap only", b, 1);
    wr(4'h8, 8'h01);
    rd(4'h8, b); check("R9 clear done", b, 0);

    // R10 set wins over same-cycle clear
    ld_cnt(24'h000001);
    cyc(1'b1, 4'h8, 8'h03, 1'b1, 1'b0);
    rd(4'h8, b); check("R10 done survives clear", b, 1);

    // R11 interrupt
    check("R11 masked irq low", irq, 0);
    wr(4'h9, 8'h01);
    rd(4'h9, b); check("R11 enable readback", b, 1);
    check("R11 done irq", irq, 1);
    wr(4'h8, 8'h01);
    check("R11 cleared irq low", irq, 0);
    wr(4'h9, 8'h02);
    ld_cnt(24'h000001);
    cyc(1'b0, 4'h0, 8'h00, 1'b1, 1'b1);   // 1 step 2 -> done and wrap
    check("R11 wrap irq", irq, 1);
    wr(4'h8, 8'h02);
    check("R11 done not enabled", irq, 0);
    wr(4'h9, 8'h00);
    wr(4'h8, 8'h03);

    // R12 write and strobe in the same cycle
    ld_cnt(24'h000001); ld_adr(32'h0000_0010);
    cyc(1'b1, 4'h0, 8'h55, 1'b1, 1'b0);
    rd_cnt(v); check("R12 write wins count", v, 32'h55);
    rd_adr(v); check("R12 addr still steps", v, 32'h11);
    rd(4'h8, b); check("R12 flag from old count", b, 1);
    ld_cnt(24'h000009);
    cyc(1'b1, 4'h4, 8'hA0, 1'b1, 1'b1);
    rd_adr(v); check("R12 write wins addr", v, 32'hA0);
    rd_cnt(v); check("R12 count still steps", v, 7);

    report();
  end
endmodule